// File: doc/BRIEF.md
# Banked GPIO Port with Atomic Set/Clear Writes

This block controls 32 general-purpose pins split into two banks of sixteen. Each bank holds its own copy of six per-pin control features: output level, output drive, input enable, two alternate-output selects and one alternate-input select. The controller also holds a synchronized view of the pin levels and sticky flags that record rising and falling edges. Software changes a control feature with a single 32-bit write. The lower half of that write turns bits on and the upper half turns bits off, so a bank changes as one atomic step and never needs a read-modify-write sequence.

The edge-flag words behave differently. A one written into their lower half clears the matching flag, and their upper half is ignored. Four pins (23, 29, 30 and 31) are reserved. They hold no state, read as zero and raise no flags.

The register bus is a plain request interface with no back-pressure. A write is taken in the cycle that `bus_wen` is high. A read is taken in the cycle that `bus_ren` is high, and its data appears on `bus_rdata` with `bus_rvalid` one cycle later. A read in the same cycle as a write returns the state from before that write. The feature levels go straight to the pad ring as plain level outputs.

Top module: `gpio_setclr_port`

## Requirements
- R1: Address bit 7 selects the bank (0 for pins 0–15, 1 for pins 16–31). Bits 6:0 select the word within the bank: 0x00 output level, 0x04 output drive, 0x10 alternate output 1, 0x14 alternate output 2, 0x20 input enable, 0x30 pin level (read-only), 0x34 alternate input 1, 0x48 rising-edge flags, 0x4C falling-edge flags. Read data appears one cycle after `bus_ren`, together with `bus_rvalid`. Bits 15:0 carry the bank's pins and bits 31:16 read 0. Any other offset reads as 0.
- R2: In a write to a feature word, a 1 in bit n (0–15) sets the feature for pin n of the bank, and a 1 in bit n+16 clears it. A pin whose two bits are both 0 keeps its value. When both bits are 1, clear wins.
- R3: A write to one bank leaves every feature bit of the other bank unchanged.
- R4: Each feature drives its own 32-bit pad output, with bit i belonging to pin i. The output takes its new value one clock after the write.
- R5: After reset, every feature bit, every edge flag, `bus_rvalid` and `bus_rdata` are 0.
- R6: The pin-level word returns `pin_in` after a two-flop synchronizer. A read issued in the same cycle that the pin changes, and the read right after it, still return the old level. The third consecutive read returns the new level.
- R7: A rising (falling) synchronized level on a pin whose input enable is 1 sets that pin's rising-edge (falling-edge) flag. The flag stays set until it is cleared.
- R8: An edge on a pin whose input enable is 0 sets no flag.
- R9: Writing a 1 to bit n (0–15) of an edge-flag word clears that pin's flag. Bits written as 0, and the whole upper half, have no effect.
- R10: If a new edge and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R11: Reserved pins 23, 29, 30 and 31 ignore feature writes. Their features, pin level and edge flags always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wen | input | 1 | Write strobe |
| bus_ren | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address: bank in bit 7, word offset in bits 6:0 |
| bus_wdata | input | 32 | Write data: set strobes in 15:0, clear strobes in 31:16 |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | High for one cycle when `bus_rdata` holds read data |
| pin_in | input | 32 | Asynchronous pin levels from the pads |
| pad_out_val | output | 32 | Output level per pin |
| pad_out_en | output | 32 | Output drive enable per pin |
| pad_in_en | output | 32 | Input enable per pin |
| pad_aux1_out | output | 32 | Alternate output 1 select per pin |
| pad_aux2_out | output | 32 | Alternate output 2 select per pin |
| pad_aux1_in | output | 32 | Alternate input 1 select per pin |

## Verification
The write-and-read-back table drives the set/clear path with several patterns, each aimed at one property:
- set-only words show that plain sets land;
- mixed words that set some pins and clear others show that both halves act in one write;
- words with both strobes for one pin show that clear wins;
- an all-zero write shows that untouched pins keep their value;
- a fully-ones write to the high bank exposes the reserved pins.

Pad outputs are compared across both banks to catch any leakage between banks. For the pin level and edge flags, the bench uses directed sequences instead:
- back-to-back reads measure the exact synchronizer latency;
- edges on disabled pins must raise no flag;
- clears written into the upper half must be ignored;
- a rising edge is timed to reach the flag in the same cycle as its clearing write.

// File: rtl/gpio_sc_pkg.sv
`timescale 1ns/1ps
package gpio_sc_pkg;

  // Per-pin control features that share the set/clear write rule.
  typedef enum int unsigned {
    FEAT_OUT_VAL  = 0,
    FEAT_OUT_EN   = 1,
    FEAT_AUX1_OUT = 2,
    FEAT_AUX2_OUT = 3,
    FEAT_IN_EN    = 4,
    FEAT_AUX1_IN  = 5
  } feat_e;

  localparam int unsigned NFEAT = 6;

  // Word offsets inside a bank (byte address, bank bit excluded).
  localparam logic [7:0] OFS_OUT_VAL  = 8'h00;
  localparam logic [7:0] OFS_OUT_EN   = 8'h04;
  localparam logic [7:0] OFS_AUX1_OUT = 8'h10;
  localparam logic [7:0] OFS_AUX2_OUT = 8'h14;
  localparam logic [7:0] OFS_IN_EN    = 8'h20;
  localparam logic [7:0] OFS_LEVEL    = 8'h30;
  localparam logic [7:0] OFS_AUX1_IN  = 8'h34;
  localparam logic [7:0] OFS_RISE     = 8'h48;
  localparam logic [7:0] OFS_FALL     = 8'h4C;

  function automatic logic [7:0] feat_offset(input int unsigned idx);
    case (idx)
      FEAT_OUT_VAL:  return OFS_OUT_VAL;
      FEAT_OUT_EN:   return OFS_OUT_EN;
      FEAT_AUX1_OUT: return OFS_AUX1_OUT;
      FEAT_AUX2_OUT: return OFS_AUX2_OUT;
      FEAT_IN_EN:    return OFS_IN_EN;
      default:       return OFS_AUX1_IN;
    endcase
  endfunction

endpackage

// File: rtl/gpio_sc_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer for asynchronous pin levels.
module gpio_sc_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1   <= '0;
      sync_out <= '0;
    end else begin
      stage1   <= async_in;
      sync_out <= stage1;
    end
  end
endmodule

// File: rtl/gpio_sc_setclr_reg.sv
`timescale 1ns/1ps
// One banked feature register updated by set/clear strobe words.
module gpio_sc_setclr_reg #(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned BANK_W = 16,
  parameter int unsigned BSEL_W = 1,
  parameter logic [NPINS-1:0] RSVD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BSEL_W-1:0] wr_bank,
  input  logic [BANK_W-1:0] set_bits,
  input  logic [BANK_W-1:0] clr_bits,
  output logic [NPINS-1:0]  q
);
  localparam int unsigned NBANK = NPINS / BANK_W;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam logic [BANK_W-1:0] KEEP = ~RSVD[b*BANK_W +: BANK_W];
    logic              hit;
    logic [BANK_W-1:0] bank_q;

    assign hit = wr_en && (wr_bank == BSEL_W'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank_q <= '0;
      end else if (hit) begin
        // clear strobes override set strobes; reserved pins never hold a 1
        bank_q <= (bank_q | set_bits) & ~clr_bits & KEEP;
      end
    end

    assign q[b*BANK_W +: BANK_W] = bank_q;
  end
endmodule

// File: rtl/gpio_sc_edge_reg.sv
`timescale 1ns/1ps
// Sticky rising/falling edge flags with write-one-to-clear per bank.
module gpio_sc_edge_reg #(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned BANK_W = 16,
  parameter int unsigned BSEL_W = 1,
  parameter logic [NPINS-1:0] RSVD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  lvl,
  input  logic [NPINS-1:0]  en,
  input  logic              clr_rise_en,
  input  logic              clr_fall_en,
  input  logic [BSEL_W-1:0] clr_bank,
  input  logic [BANK_W-1:0] clr_bits,
  output logic [NPINS-1:0]  rise_q,
  output logic [NPINS-1:0]  fall_q
);
  localparam int unsigned NBANK = NPINS / BANK_W;

  logic [NPINS-1:0] prev_lvl;
  logic [NPINS-1:0] rise_evt;
  logic [NPINS-1:0] fall_evt;
  logic [NPINS-1:0] rise_clr;
  logic [NPINS-1:0] fall_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_lvl <= '0;
    else        prev_lvl <= lvl;
  end

  assign rise_evt = lvl & ~prev_lvl & en & ~RSVD;
  assign fall_evt = ~lvl & prev_lvl & en & ~RSVD;

  for (genvar b = 0; b < NBANK; b++) begin : g_clr
    logic hit;
    assign hit = (clr_bank == BSEL_W'(b));
    assign rise_clr[b*BANK_W +: BANK_W] = (clr_rise_en && hit) ? clr_bits : '0;
    assign fall_clr[b*BANK_W +: BANK_W] = (clr_fall_en && hit) ? clr_bits : '0;
  end

  // a fresh edge is ORed in after the clear so it is never lost
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= '0;
      fall_q <= '0;
    end else begin
      rise_q <= (rise_q & ~rise_clr) | rise_evt;
      fall_q <= (fall_q & ~fall_clr) | fall_evt;
    end
  end
endmodule

// File: rtl/gpio_setclr_port.sv
`timescale 1ns/1ps
module gpio_setclr_port
  import gpio_sc_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned BANK_W = 16,
  parameter int unsigned ADDR_W = 8,
  parameter logic [NPINS-1:0] RSVD_MASK = 32'hE080_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wen,
  input  logic              bus_ren,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [2*BANK_W-1:0] bus_wdata,
  output logic [2*BANK_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pad_out_val,
  output logic [NPINS-1:0]  pad_out_en,
  output logic [NPINS-1:0]  pad_in_en,
  output logic [NPINS-1:0]  pad_aux1_out,
  output logic [NPINS-1:0]  pad_aux2_out,
  output logic [NPINS-1:0]  pad_aux1_in
);
  localparam int unsigned NBANK  = NPINS / BANK_W;
  localparam int unsigned BSEL_W = $clog2(NBANK);
  localparam int unsigned OFS_W  = ADDR_W - BSEL_W;
  localparam int unsigned DATA_W = 2 * BANK_W;

  logic [BSEL_W-1:0] sel_bank;
  logic [OFS_W-1:0]  sel_ofs;
  logic [BANK_W-1:0] set_bits;
  logic [BANK_W-1:0] clr_bits;

  assign sel_bank = bus_addr[ADDR_W-1 -: BSEL_W];
  assign sel_ofs  = bus_addr[OFS_W-1:0];
  assign set_bits = bus_wdata[BANK_W-1:0];
  assign clr_bits = bus_wdata[DATA_W-1:BANK_W];

  // ---------------- feature registers ----------------
  logic [NPINS-1:0] feat_q [NFEAT];

  for (genvar f = 0; f < NFEAT; f++) begin : g_feat
    logic hit;
    assign hit = bus_wen && (sel_ofs == OFS_W'(feat_offset(f)));

    gpio_sc_setclr_reg #(
      .NPINS (NPINS),
      .BANK_W(BANK_W),
      .BSEL_W(BSEL_W),
      .RSVD  (RSVD_MASK)
    ) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (hit),
      .wr_bank (sel_bank),
      .set_bits(set_bits),
      .clr_bits(clr_bits),
      .q       (feat_q[f])
    );
  end

  assign pad_out_val  = feat_q[FEAT_OUT_VAL];
  assign pad_out_en   = feat_q[FEAT_OUT_EN];
  assign pad_in_en    = feat_q[FEAT_IN_EN];
  assign pad_aux1_out = feat_q[FEAT_AUX1_OUT];
  assign pad_aux2_out = feat_q[FEAT_AUX2_OUT];
  assign pad_aux1_in  = feat_q[FEAT_AUX1_IN];

  // ---------------- input path ----------------
  logic [NPINS-1:0] pin_sync;
  logic [NPINS-1:0] pin_lvl;
  logic [NPINS-1:0] rise_flags;
  logic [NPINS-1:0] fall_flags;

  gpio_sc_sync #(.W(NPINS)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(pin_in),
    .sync_out(pin_sync)
  );

  assign pin_lvl = pin_sync & ~RSVD_MASK;

  logic clr_rise_en;
  logic clr_fall_en;
  assign clr_rise_en = bus_wen && (sel_ofs == OFS_W'(OFS_RISE));
  assign clr_fall_en = bus_wen && (sel_ofs == OFS_W'(OFS_FALL));

  gpio_sc_edge_reg #(
    .NPINS (NPINS),
    .BANK_W(BANK_W),
    .BSEL_W(BSEL_W),
    .RSVD  (RSVD_MASK)
  ) u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .lvl        (pin_lvl),
    .en         (pad_in_en),
    .clr_rise_en(clr_rise_en),
    .clr_fall_en(clr_fall_en),
    .clr_bank   (sel_bank),
    .clr_bits   (set_bits),
    .rise_q     (rise_flags),
    .fall_q     (fall_flags)
  );

  // ---------------- read path ----------------
  logic [BANK_W-1:0] rd_word;
  int unsigned       rd_base;

  always_comb begin
    rd_base = int'(sel_bank) * BANK_W;
    rd_word = '0;
    for (int f = 0; f < NFEAT; f++) begin
      if (sel_ofs == OFS_W'(feat_offset(f))) rd_word = feat_q[f][rd_base +: BANK_W];
    end
    if (sel_ofs == OFS_W'(OFS_LEVEL)) rd_word = pin_lvl[rd_base +: BANK_W];
    if (sel_ofs == OFS_W'(OFS_RISE))  rd_word = rise_flags[rd_base +: BANK_W];
    if (sel_ofs == OFS_W'(OFS_FALL))  rd_word = fall_flags[rd_base +: BANK_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_ren;
      if (bus_ren) bus_rdata <= {{BANK_W{1'b0}}, rd_word};
    end
  end
endmodule

// File: rtl/gpio_sc_checker.sv
`timescale 1ns/1ps
module gpio_sc_checker #(
  parameter int unsigned NPINS = 32,
  parameter logic [NPINS-1:0] RSVD = '0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wen,
  input logic             bus_ren,
  input logic [7:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic             bus_rvalid,
  input logic [NPINS-1:0] pad_out_val,
  input logic [NPINS-1:0] pad_out_en,
  input logic [NPINS-1:0] pad_in_en,
  input logic [NPINS-1:0] pad_aux1_out,
  input logic [NPINS-1:0] pad_aux2_out,
  input logic [NPINS-1:0] pad_aux1_in,
  input logic [NPINS-1:0] rise_flags,
  input logic [NPINS-1:0] fall_flags
);
  // R1: read strobe produces exactly one valid cycle later
  p_rvalid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ren |=> bus_rvalid);
  p_rvalid_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ren |=> !bus_rvalid);

  // R2: clear strobe always leaves the bit at 0
  p_clear_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wen && bus_addr == 8'h00) |=>
      ((pad_out_val[15:0] & $past(bus_wdata[31:16])) == 16'h0));

  // R2: set strobe without clear leaves the bit at 1
  p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wen && bus_addr == 8'h00) |=>
      ((pad_out_val[15:0] & $past(bus_wdata[15:0] & ~bus_wdata[31:16] & ~RSVD[15:0]))
        == $past(bus_wdata[15:0] & ~bus_wdata[31:16] & ~RSVD[15:0])));

  // R3: low-bank write leaves the high bank alone
  p_bank_isolated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wen && !bus_addr[7]) |=> $stable(pad_out_en[NPINS-1:16]));

  // R8: no flag appears on a pin whose input was disabled
  p_no_flag_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rise_flags & ~$past(rise_flags) & ~$past(pad_in_en)) == '0));

  // R9: rising flags only drop after a clearing write
  p_flags_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wen && bus_addr[6:0] == 7'h48) |=>
      ((rise_flags & $past(rise_flags)) == $past(rise_flags)));

  // R11: reserved pins never hold state
  p_rsvd_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (((pad_out_val | pad_out_en | pad_in_en | pad_aux1_out | pad_aux2_out |
       pad_aux1_in | rise_flags | fall_flags) & RSVD) == '0));
endmodule

bind gpio_setclr_port gpio_sc_checker #(.NPINS(NPINS), .RSVD(RSVD_MASK)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_wen     (bus_wen),
  .bus_ren     (bus_ren),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_rvalid  (bus_rvalid),
  .pad_out_val (pad_out_val),
  .pad_out_en  (pad_out_en),
  .pad_in_en   (pad_in_en),
  .pad_aux1_out(pad_aux1_out),
  .pad_aux2_out(pad_aux2_out),
  .pad_aux1_in (pad_aux1_in),
  .rise_flags  (rise_flags),
  .fall_flags  (fall_flags)
);

// File: tb/test_gpio_setclr_port.sv
`timescale 1ns/1ps
module test_gpio_setclr_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wen = 1'b0;
  logic        bus_ren = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [31:0] pin_in = '0;
  logic [31:0] pad_out_val, pad_out_en, pad_in_en;
  logic [31:0] pad_aux1_out, pad_aux2_out, pad_aux1_in;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  gpio_setclr_port i_gpio_setclr_port (
    .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_ren(bus_ren),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .pin_in(pin_in), .pad_out_val(pad_out_val),
    .pad_out_en(pad_out_en), .pad_in_en(pad_in_en), .pad_aux1_out(pad_aux1_out),
    .pad_aux2_out(pad_aux2_out), .pad_aux1_in(pad_aux1_in)
  );

  // {addr, write data, expected low half on read-back}
  localparam int NV = 14;
  localparam logic [55:0] VEC [NV] = '{
    {8'h00, 32'h0000_00FF, 16'h00FF},  // R2 plain set
    {8'h00, 32'h000F_0100, 16'h01F0},  // R2 set and clear in one word
    {8'h00, 32'h0010_0010, 16'h01E0},  // R2 both strobes: clear wins
    {8'h80, 32'h0000_FFFF, 16'h1F7F},  // R11 reserved ignore sets
    {8'h00, 32'h0000_0000, 16'h01E0},  // R2/R3 zeros keep, high write did not leak
    {8'h04, 32'h0000_8001, 16'h8001},
    {8'h84, 32'hFFFF_FFFF, 16'h0000},  // R2 clear wins on every pin
    {8'h10, 32'h0000_A5A5, 16'hA5A5},
    {8'h14, 32'h0000_5A5A, 16'h5A5A},
    {8'h20, 32'h0000_FFFF, 16'hFFFF},
    {8'h34, 32'h0000_0F0F, 16'h0F0F},
    {8'h90, 32'h0000_00FF, 16'h007F},  // R11 pin 23 reserved
    {8'h10, 32'h00FF_0000, 16'hA500},
    {8'h0C, 32'hFFFF_FFFF, 16'h0000}   // R1 unmapped offset reads 0
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_ren = 1'b1; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_ren = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    repeat (3) @(negedge clk);
    // R5 reset state
    chk("R5 out_val", pad_out_val, '0);
    chk("R5 out_en", pad_out_en, '0);
    chk("R5 in_en", pad_in_en, '0);
    chk("R5 aux", pad_aux1_out | pad_aux2_out | pad_aux1_in, '0);
    chk("R5 rvalid", {31'b0, bus_rvalid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(8'h48, d); chk("R5 rise flags", d, '0);
    chk("R1 rvalid after read", {31'b0, bus_rvalid}, 32'h1);
    @(negedge clk);
    chk("R1 rvalid idle", {31'b0, bus_rvalid}, 32'h0);

    // table walk: R1 R2 R3 R11
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][55:48], VEC[i][47:16]);
      rd(VEC[i][55:48], d);
      chk($sformatf("R2 vector %0d", i), d, {16'h0, VEC[i][15:0]});
    end

    // R4 pad outputs, R3 bank separation
    chk("R4 out_val", pad_out_val, 32'h1F7F_01E0);
    chk("R4 out_en", pad_out_en, 32'h0000_8001);
    chk("R4 aux1_out", pad_aux1_out, 32'h007F_A500);
    chk("R4 aux2_out", pad_aux2_out, 32'h0000_5A5A);
    chk("R4 in_en", pad_in_en, 32'h0000_FFFF);
    chk("R4 aux1_in", pad_aux1_in, 32'h0000_0F0F);

    // R6 synchronizer latency
    pin_in = 32'hF0A5_5678;
    rd(8'h30, d); chk("R6 same-cycle read old", d, 32'h0);
    rd(8'h30, d); chk("R6 second read old", d, 32'h0);
    rd(8'h30, d); chk("R6 third read new", d, 32'h0000_5678);
    rd(8'hB0, d); chk("R6 R11 high level", d, 32'h0000_1025);

    // R7 rising flags on enabled low bank; R8 none on disabled high bank
    settle();
    rd(8'h48, d); chk("R7 rise low", d, 32'h0000_5678);
    rd(8'hC8, d); chk("R8 rise high disabled", d, 32'h0);
    rd(8'h4C, d); chk("R7 fall low empty", d, 32'h0);
    pin_in = 32'h0;
    settle();
    rd(8'h4C, d); chk("R7 fall low", d, 32'h0000_5678);
    rd(8'hCC, d); chk("R8 fall high disabled", d, 32'h0);

    // R9 upper half ignored, lower half clears
    wr(8'h48, 32'hFFFF_0000);
    rd(8'h48, d); chk("R9 upper half ignored", d, 32'h0000_5678);
    wr(8'h48, 32'h0000_0008);
    rd(8'h48, d); chk("R9 w1c", d, 32'h0000_5670);

    // R7 R11 high bank once enabled
    wr(8'hA0, 32'h0000_FFFF);
    pin_in = 32'hFFFF_0000;
    settle();
    rd(8'hC8, d); chk("R7 R11 rise high", d, 32'h0000_1F7F);

    // R10 edge beats simultaneous clear on pin 0
    pin_in[0] = 1'b1;
    settle();
    rd(8'h48, d); chk("R7 pin0 rise", d, 32'h0000_5671);
    pin_in[0] = 1'b0;
    settle();
    pin_in[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr(8'h48, 32'h0000_0001);  // lands on the edge that sees the new level
    rd(8'h48, d); chk("R10 edge wins over clear", d, 32'h0000_5671);
    wr(8'h48, 32'h0000_0001);
    rd(8'h48, d); chk("R9 clear without edge", d, 32'h0000_5670);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule